// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block is a bank of instruction-address comparators for a processor debug subsystem. Each comparator holds one address register. A single shared arm register decides which comparators take part. Both kinds of register are loaded through a one-cycle register-write port. In every cycle the unit compares the fetch program counter with each armed comparator. It reports which comparators matched on a per-comparator vector and on one combined hit line.

Hits are held back while the core runs at or above the configured debug interrupt level, and also while the fetch address is not qualified as valid. Debug control logic uses the combined hit to start its halt sequence, and the vector to record which comparator fired. Exception entry and halt sequencing sit outside this block.

Top module: `ibp_unit`

## Requirements
- R1: A write to the arm register (`cfg_sel` most significant bit 0; the lower select bits are ignored) keeps only bits `NUM_CMP-1:0` of `cfg_wdata`. Bits at or above `NUM_CMP` are discarded. `bp_armed` shows the stored arm bits from the next cycle on.
- R2: Comparator i reports a match only when arm bit i is set and its stored address equals `fetch_pc` exactly, on every bit.
- R3: While `cur_level` is greater than or equal to `DEBUG_LVL` (default 6), `bp_hit_vec` and `bp_hit` are all zero, even when a comparator matches.
- R4: `bp_hit` is the OR of all bits of `bp_hit_vec`.
- R5: Writing a new address to an armed comparator changes what it matches without any change to the arm register.
- R6: A write to address register i uses `cfg_sel = {1'b1, i}`, with i in the low `IDX_W` bits. The new value is used by the compare from the cycle after the write edge. In the write cycle itself the old value is still in use.
- R7: After reset all arm bits are zero, all address registers are zero, and no hit is reported.
- R8: While `fetch_valid` is low, `bp_hit_vec` and `bp_hit` are zero.
- R9: When several armed comparators hold the same matching address, every one of them is flagged in `bp_hit_vec` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | IDX_W+1 | Write target: MSB 0 selects the arm register, MSB 1 selects the address register given by the low bits |
| cfg_wdata | input | DATA_W | Write data |
| fetch_pc | input | ADDR_W | Current fetch program counter |
| fetch_valid | input | 1 | Qualifies `fetch_pc` |
| cur_level | input | LVL_W | Current interrupt level of the core |
| bp_hit | output | 1 | Any comparator hit after gating |
| bp_hit_vec | output | NUM_CMP | Per-comparator hit after gating |
| bp_armed | output | NUM_CMP | Current arm register contents |

## Verification
A wrong arm bit is visible at once on `bp_armed`, one cycle after the write that stored it. It also shows in the first fetch cycle whose address equals that comparator's address. A corrupted address register stays hidden until the program counter reaches either the old address or the new one. For that reason the bench presents both addresses directly after each rewrite. A broken level gate or valid qualifier corrupts `bp_hit_vec` in the same cycle, because the output path holds no register in the default configuration.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
   // Decoded kind of a register write.
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_ARM  = 2'd1,
      WR_ADDR = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/ibp_regs.sv
module ibp_regs #(
   parameter int NUM_CMP = 4,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [IDX_W:0]                cfg_sel,
   input  logic [DATA_W-1:0]             cfg_wdata,
   output logic [NUM_CMP-1:0]            arm_q,
   output logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q
);
   import ibp_pkg::*;

   wr_kind_e             kind;
   logic [IDX_W-1:0]     idx;

   assign idx = cfg_sel[IDX_W-1:0];

   always_comb begin
      if (!cfg_we)
         kind = WR_NONE;
      else if (cfg_sel[IDX_W])
         kind = WR_ADDR;
      else
         kind = WR_ARM;
   end

   // Arm register: bits at or above NUM_CMP are never stored.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         arm_q <= '0;
      else if (kind == WR_ARM)
         arm_q <= cfg_wdata[NUM_CMP-1:0];
   end

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_q[g] <= '0;
         else if (kind == WR_ADDR && idx == IDX_W'(g))
            addr_q[g] <= cfg_wdata[ADDR_W-1:0];
      end
   end
endmodule

// File: rtl/ibp_match.sv
module ibp_match #(
   parameter int ADDR_W = 32
) (
   input  logic              armed,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] pc,
   input  logic              qual,
   output logic              hit
);
   assign hit = armed && qual && (ref_addr == pc);
endmodule

// File: rtl/ibp_unit.sv
module ibp_unit #(
   parameter int NUM_CMP   = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int LVL_W     = 4,
   parameter int DEBUG_LVL = 6,
   parameter bit HIT_REG   = 1'b0,
   localparam int IDX_W    = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
   localparam int SEL_W    = IDX_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [SEL_W-1:0]   cfg_sel,
   input  logic [DATA_W-1:0]  cfg_wdata,
   input  logic [ADDR_W-1:0]  fetch_pc,
   input  logic               fetch_valid,
   input  logic [LVL_W-1:0]   cur_level,
   output logic               bp_hit,
   output logic [NUM_CMP-1:0] bp_hit_vec,
   output logic [NUM_CMP-1:0] bp_armed
);
   localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DEBUG_LVL);

   if (NUM_CMP < 1 || NUM_CMP > DATA_W) begin : g_bad_cnt
      $error("ibp_unit: NUM_CMP must be 1..DATA_W");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("ibp_unit: ADDR_W must be 1..DATA_W");
   end
   if (DEBUG_LVL < 0 || DEBUG_LVL >= (1 << LVL_W)) begin : g_bad_lvl
      $error("ibp_unit: DEBUG_LVL does not fit LVL_W");
   end

   logic [NUM_CMP-1:0]             arm_q;
   logic [NUM_CMP-1:0][ADDR_W-1:0] addr_q;
   logic [NUM_CMP-1:0]             raw_hit;
   logic                           lvl_ok;
   logic [NUM_CMP-1:0]             gated;

   ibp_regs #(
      .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .arm_q(arm_q), .addr_q(addr_q)
   );

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      ibp_match #(.ADDR_W(ADDR_W)) u_match (
         .armed(arm_q[g]), .ref_addr(addr_q[g]), .pc(fetch_pc),
         .qual(fetch_valid), .hit(raw_hit[g])
      );
   end

   assign lvl_ok = (cur_level < DBG_LVL_V);
   assign gated  = lvl_ok ? raw_hit : '0;

   if (HIT_REG) begin : g_out_reg
      logic [NUM_CMP-1:0] vec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vec_q <= '0;
         else        vec_q <= gated;
      end
      assign bp_hit_vec = vec_q;
   end else begin : g_out_comb
      assign bp_hit_vec = gated;
   end

   assign bp_hit   = |bp_hit_vec;
   assign bp_armed = arm_q;
endmodule

// File: rtl/ibp_unit_chk.sv
module ibp_unit_chk #(
   parameter int NUM_CMP   = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int LVL_W     = 4,
   parameter int DEBUG_LVL = 6,
   parameter bit HIT_REG   = 1'b0,
   parameter int SEL_W     = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [SEL_W-1:0]   cfg_sel,
   input logic [DATA_W-1:0]  cfg_wdata,
   input logic [ADDR_W-1:0]  fetch_pc,
   input logic               fetch_valid,
   input logic [LVL_W-1:0]   cur_level,
   input logic               bp_hit,
   input logic [NUM_CMP-1:0] bp_hit_vec,
   input logic [NUM_CMP-1:0] bp_armed
);
   localparam logic [LVL_W-1:0] LV = LVL_W'(DEBUG_LVL);

   p_arm_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel[SEL_W-1]) |=> bp_armed == $past(cfg_wdata[NUM_CMP-1:0]));

   p_arm_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(bp_armed));

   p_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bp_hit == (|bp_hit_vec));

   if (!HIT_REG) begin : g_comb
      p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cur_level >= LV) |-> bp_hit_vec == '0);
      p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !fetch_valid |-> bp_hit_vec == '0);
      p_armed_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bp_hit_vec & ~bp_armed) == '0);
   end else begin : g_reg
      p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cur_level >= LV) |=> bp_hit_vec == '0);
      p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !fetch_valid |=> bp_hit_vec == '0);
      p_armed_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (bp_hit_vec & ~$past(bp_armed)) == '0);
   end
endmodule

bind ibp_unit ibp_unit_chk #(
   .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
   .DEBUG_LVL(DEBUG_LVL), .HIT_REG(HIT_REG), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/sim_ibp_unit.sv
module sim_ibp_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_valid = 1'b0;
   logic [3:0]  cur_level = '0;
   logic        bp_hit;
   logic [3:0]  bp_hit_vec;
   logic [3:0]  bp_armed;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ibp_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
      .cur_level(cur_level), .bp_hit(bp_hit), .bp_hit_vec(bp_hit_vec),
      .bp_armed(bp_armed)
   );

   // {pc, valid, level, expected vector}
   typedef struct packed {
      logic [31:0] pc;
      logic        vld;
      logic [3:0]  lvl;
      logic [3:0]  exp;
   } vec_t;

   localparam vec_t TBL [9] = '{
      '{32'h1000, 1'b1, 4'd0,  4'b0101},
      '{32'h2000, 1'b1, 4'd3,  4'b0010},
      '{32'h3000, 1'b1, 4'd0,  4'b0000},
      '{32'h1000, 1'b1, 4'd5,  4'b0101},
      '{32'h1000, 1'b1, 4'd6,  4'b0000},
      '{32'h2000, 1'b1, 4'd15, 4'b0000},
      '{32'h1000, 1'b0, 4'd0,  4'b0000},
      '{32'h1004, 1'b1, 4'd0,  4'b0000},
      '{32'h2001, 1'b1, 4'd0,  4'b0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic fetch(input logic [31:0] pc, input logic v, input logic [3:0] l);
      @(negedge clk);
      fetch_pc = pc; fetch_valid = v; cur_level = l;
      #2;
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R7: reset state, address 0 matches pc 0 only if armed
      fetch(32'h0, 1'b1, 4'd0);
      chk("R7 armed", 32'(bp_armed), 32'h0);
      chk("R7 vec", 32'(bp_hit_vec), 32'h0);
      chk("R7 hit", 32'(bp_hit), 32'h0);

      wr(3'b100, 32'h1000);
      wr(3'b101, 32'h2000);
      wr(3'b110, 32'h1000);
      wr(3'b111, 32'h3000);
      // R1: upper bits dropped, low select bits ignored for the arm write
      wr(3'b011, 32'hFFFF_FFF7);
      chk("R1 armed", 32'(bp_armed), 32'h7);

      // R2 R3 R4 R8 R9 from the table
      foreach (TBL[i]) begin
         fetch(TBL[i].pc, TBL[i].vld, TBL[i].lvl);
         chk("R2/R3/R8/R9 vec", 32'(bp_hit_vec), 32'(TBL[i].exp));
         chk("R4 hit", 32'(bp_hit), 32'(|TBL[i].exp));
      end

      // R6: write cycle still uses old address; next cycle uses new one
      fetch(32'h2000, 1'b1, 4'd0);
      cfg_we = 1'b1; cfg_sel = 3'b101; cfg_wdata = 32'h2100;
      #1;
      chk("R6 old value in write cycle", 32'(bp_hit_vec), 32'h2);
      @(negedge clk);
      cfg_we = 1'b0;
      #2;
      chk("R6 old address gone", 32'(bp_hit_vec), 32'h0);
      // R5: new address matches without re-arming
      fetch(32'h2100, 1'b1, 4'd0);
      chk("R5 new address hit", 32'(bp_hit_vec), 32'h2);
      chk("R5 armed unchanged", 32'(bp_armed), 32'h7);

      // R2: arm comparator 3 only, its address now matches
      wr(3'b000, 32'h8);
      fetch(32'h3000, 1'b1, 4'd0);
      chk("R2 cmp3 armed hit", 32'(bp_hit_vec), 32'h8);
      fetch(32'h1000, 1'b1, 4'd0);
      chk("R2 disarmed no hit", 32'(bp_hit_vec), 32'h0);

      // R3 boundary: level one below debug level still hits
      fetch(32'h3000, 1'b1, 4'd5);
      chk("R3 level 5 hit", 32'(bp_hit), 32'h1);
      fetch(32'h3000, 1'b1, 4'd6);
      chk("R3 level 6 gated", 32'(bp_hit), 32'h0);

      // R7: reset mid-run clears arm and address
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      wr(3'b000, 32'hF);
      fetch(32'h0, 1'b1, 4'd0);
      chk("R7 addresses cleared", 32'(bp_hit_vec), 32'hF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule